// File: doc/BRIEF.md
# Software-Managed Set-Associative Translation Buffer

This block holds the main translation buffer of a memory management unit in a set-associative RAM. Software maintains it entirely through four word-wide registers: a virtual-side descriptor, a physical-side descriptor, an index register and a command register. Writing a code to the command register starts one operation. Operations can look up a virtual page and address-space tag in one set, read or write the entry that the index register selects, find a slot to fill, or flush the small translation caches downstream.

Each entry occupies linear slot `set * WAYS + way`, so the ways of one set sit at consecutive indices. A lookup that hits exactly once returns that slot. A lookup that misses, or that hits more than once, returns an error word. The slot-finding command prefers an empty way and falls back to a per-set round-robin victim. Two write commands exist. The normal one also pulses the downstream invalidate output. The other leaves the downstream caches intact, which suits refills after a miss, where the evicted translation is still correct.

Top module: `sw_tlb`

## Requirements
- R1: After reset, the virtual descriptor (register 0), the physical descriptor (register 1) and the index register (register 2) read as zero, and `busy_o` and `utlb_inv_o` are low.
- R2: A command is started by writing code 1 to 6 into bits [2:0] of register 3 while idle. `busy_o` is then high for exactly the next two cycles, and results are readable once it falls.
- R3: Write commands (code 2 normal, code 3 no-invalidate) store registers 0 and 1 into the slot that the index register selects. Index bits [WAY_W-1:0] give the way and the bits above them give the set. Read (code 1) copies that slot back into registers 0 and 1.
- R4: Probe (code 4) compares the key in register 0 against every way of the set given by register 0 bits [PAGE_BITS+SET_W-1:PAGE_BITS]. A way matches when its bit 8 (valid) is set and both its bits [31:PAGE_BITS] (page number) and bits [7:0] (address-space tag) equal the key's. A single match loads the index register with `set*WAYS+way`, with bit 31 clear.
- R5: A probe with no match loads the index register with 0x8000_0000 (bit 31 is the lookup-error flag).
- R6: A probe matching two or more ways loads the index register with 0x8000_0001 (bit 0 marks a duplicate).
- R7: A slot written with both descriptors zero never matches a probe, even one whose key is zero or carries only the valid bit.
- R8: Get-slot (code 5) takes the set from register 0 as probe does. If that set has an empty way, it loads the index register with the lowest-numbered empty way's linear index.
- R9: When every way of the set is valid, get-slot returns the way under that set's round-robin pointer and advances it. Pointers start at way 0 after reset, wrap after the last way, and are independent per set.
- R10: A normal write pulses `utlb_inv_o` for one cycle, in the first cycle after `busy_o` falls. A no-invalidate write never pulses it.
- R11: Invalidate (code 6) gives the same one-cycle pulse and leaves the array contents unchanged.
- R12: Register writes while `busy_o` is high are ignored. Command codes 0 and 7 start nothing and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 virtual descriptor, 1 physical descriptor, 2 index, 3 command |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational; register 3 reads zero) |
| busy_o | output | 1 | Command in progress |
| utlb_inv_o | output | 1 | One-cycle invalidate pulse to the downstream translation caches |

## Verification
The bench uses an 8-set, 4-way configuration. It first fills every slot with a descriptor built from its own linear index, then reads each slot back and probes for it. A slot/set/way mapping error therefore shows up as a wrong slot, not as a silent hit. Misses use a wrong tag, a cleared array and an all-zero key, which separates valid-bit gating from plain tag comparison. A deliberately duplicated page separates the duplicate code from the single-hit code. Get-slot is tried on a set with one hole, a set with two holes and full sets, so the lowest-empty preference, the wrap of the round-robin pointer and per-set independence each show up on their own.

// File: rtl/sw_tlb_pkg.sv
`timescale 1ns/1ps
package sw_tlb_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned ASID_W    = 8;
  localparam int unsigned VALID_BIT = 8;
  localparam int unsigned ERR_BIT   = 31;

  localparam logic [REG_W-1:0] ERR_MISS = REG_W'(1) << ERR_BIT;
  localparam logic [REG_W-1:0] ERR_DUP  = (REG_W'(1) << ERR_BIT) | REG_W'(1);

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_READ     = 3'd1,
    CMD_WRITE    = 3'd2,
    CMD_WRITE_NI = 3'd3,
    CMD_PROBE    = 3'd4,
    CMD_GET_IDX  = 3'd5,
    CMD_INV_UTLB = 3'd6
  } tlb_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EXEC
  } tlb_state_e;

  typedef enum logic [1:0] {
    RA_PD0   = 2'd0,
    RA_PD1   = 2'd1,
    RA_INDEX = 2'd2,
    RA_CMD   = 2'd3
  } tlb_reg_e;

  typedef struct packed {
    logic [REG_W-1:0] pd0;
    logic [REG_W-1:0] pd1;
  } tlb_entry_t;
endpackage

// File: rtl/sw_tlb_array.sv
`timescale 1ns/1ps
module sw_tlb_array
  import sw_tlb_pkg::*;
#(
  parameter int unsigned SETS = 128,
  parameter int unsigned WAYS = 2,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rd_en_i,
  input  logic [SET_W-1:0]       rd_set_i,
  output tlb_entry_t [WAYS-1:0]  rd_o,
  input  logic                   we_i,
  input  logic [SET_W-1:0]       wr_set_i,
  input  logic [WAY_W-1:0]       wr_way_i,
  input  tlb_entry_t             wr_data_i
);
  // one bank per way, whole set read in a single cycle
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_entry_t mem_q [SETS];
    tlb_entry_t rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && wr_way_i == WAY_W'(w)) mem_q[wr_set_i] <= wr_data_i;
      if (rd_en_i) rd_q <= mem_q[rd_set_i];
    end

    assign rd_o[w] = rd_q;
  end
endmodule

// File: rtl/sw_tlb_match.sv
`timescale 1ns/1ps
module sw_tlb_match
  import sw_tlb_pkg::*;
#(
  parameter int unsigned WAYS      = 2,
  parameter int unsigned PAGE_BITS = 13,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [REG_W-1:0]      key_i,
  input  tlb_entry_t [WAYS-1:0] ent_i,
  output logic [WAYS-1:0]       hit_o,
  output logic [WAY_W-1:0]      hit_way_o,
  output logic                  multi_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_o[w] = ent_i[w].pd0[VALID_BIT]
                   && (ent_i[w].pd0[REG_W-1:PAGE_BITS] == key_i[REG_W-1:PAGE_BITS])
                   && (ent_i[w].pd0[ASID_W-1:0] == key_i[ASID_W-1:0]);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_o[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign multi_o = ($countones(hit_o) > 1);
endmodule

// File: rtl/sw_tlb_victim.sv
`timescale 1ns/1ps
module sw_tlb_victim #(
  parameter int unsigned SETS = 128,
  parameter int unsigned WAYS = 2,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] free_way;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[set_i] <= (ptr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[set_i] + WAY_W'(1);
    end
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = WAY_W'(w);
    end
  end

  assign full_o = &valid_i;
  assign way_o  = full_o ? ptr_q[set_i] : free_way;
endmodule

// File: rtl/sw_tlb.sv
`timescale 1ns/1ps
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter int unsigned SETS      = 128,
  parameter int unsigned WAYS      = 2,
  parameter int unsigned PAGE_BITS = 13,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        busy_o,
  output logic        utlb_inv_o
);
  logic [REG_W-1:0] pd0_q, pd1_q, index_q;
  tlb_cmd_e         cmd_q;
  tlb_state_e       state_q;
  logic             utlb_q;

  logic [SET_W-1:0] va_set, ix_set, rd_set;
  logic [WAY_W-1:0] ix_way, hit_way, vic_way;
  logic             use_va, exec, wr_en, rd_en, vic_full, vic_adv, multi;
  logic [WAYS-1:0]  hit, way_valid;
  tlb_entry_t [WAYS-1:0] set_rd;
  tlb_entry_t       sel_ent;
  logic             cmd_ok;

  function automatic logic [REG_W-1:0] slot_word(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
    return REG_W'({s, w});
  endfunction

  assign va_set = pd0_q[PAGE_BITS +: SET_W];
  assign ix_set = index_q[WAY_W +: SET_W];
  assign ix_way = index_q[WAY_W-1:0];
  assign use_va = (cmd_q == CMD_PROBE) || (cmd_q == CMD_GET_IDX);
  assign rd_set = use_va ? va_set : ix_set;
  assign rd_en  = (state_q == ST_LOOK);
  assign exec   = (state_q == ST_EXEC);
  assign wr_en  = exec && ((cmd_q == CMD_WRITE) || (cmd_q == CMD_WRITE_NI));
  assign sel_ent = set_rd[ix_way];
  assign cmd_ok = (reg_wdata_i[2:0] != 3'd0) && (reg_wdata_i[2:0] != 3'd7);

  for (genvar w = 0; w < WAYS; w++) begin : g_valid
    assign way_valid[w] = set_rd[w].pd0[VALID_BIT];
  end

  sw_tlb_array #(.SETS(SETS), .WAYS(WAYS)) u_array (
    .clk_i     (clk_i),
    .rd_en_i   (rd_en),
    .rd_set_i  (rd_set),
    .rd_o      (set_rd),
    .we_i      (wr_en),
    .wr_set_i  (ix_set),
    .wr_way_i  (ix_way),
    .wr_data_i ('{pd0: pd0_q, pd1: pd1_q})
  );

  sw_tlb_match #(.WAYS(WAYS), .PAGE_BITS(PAGE_BITS)) u_match (
    .key_i     (pd0_q),
    .ent_i     (set_rd),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .multi_o   (multi)
  );

  assign vic_adv = exec && (cmd_q == CMD_GET_IDX) && vic_full;

  sw_tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (va_set),
    .valid_i (way_valid),
    .adv_i   (vic_adv),
    .way_o   (vic_way),
    .full_o  (vic_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd0_q   <= '0;
      pd1_q   <= '0;
      index_q <= '0;
      cmd_q   <= CMD_NONE;
      state_q <= ST_IDLE;
      utlb_q  <= 1'b0;
    end else begin
      utlb_q <= exec && ((cmd_q == CMD_WRITE) || (cmd_q == CMD_INV_UTLB));
      case (state_q)
        ST_IDLE: begin
          if (reg_we_i) begin
            case (tlb_reg_e'(reg_addr_i))
              RA_PD0:   pd0_q   <= reg_wdata_i;
              RA_PD1:   pd1_q   <= reg_wdata_i;
              RA_INDEX: index_q <= reg_wdata_i;
              default: begin
                if (cmd_ok) begin
                  cmd_q   <= tlb_cmd_e'(reg_wdata_i[2:0]);
                  state_q <= ST_LOOK;
                end
              end
            endcase
          end
        end
        ST_LOOK: state_q <= ST_EXEC;
        ST_EXEC: begin
          state_q <= ST_IDLE;
          case (cmd_q)
            CMD_READ: begin
              pd0_q <= sel_ent.pd0;
              pd1_q <= sel_ent.pd1;
            end
            CMD_PROBE: begin
              if (hit == '0)  index_q <= ERR_MISS;
              else if (multi) index_q <= ERR_DUP;
              else            index_q <= slot_word(va_set, hit_way);
            end
            CMD_GET_IDX: index_q <= slot_word(va_set, vic_way);
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (tlb_reg_e'(reg_addr_i))
      RA_PD0:   reg_rdata_o = pd0_q;
      RA_PD1:   reg_rdata_o = pd1_q;
      RA_INDEX: reg_rdata_o = index_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign utlb_inv_o = utlb_q;
endmodule

// File: rtl/sw_tlb_chk.sv
`timescale 1ns/1ps
module sw_tlb_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        busy_o,
  input logic        utlb_inv_o,
  input logic [31:0] pd0_q
);
  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |=> !busy_o);

  // R10
  inv_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utlb_inv_o |-> (!busy_o && $past(busy_o)));

  // R10
  inv_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utlb_inv_o |=> !utlb_inv_o);

  // R12
  busy_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && reg_we_i && reg_addr_i == 2'd0) |=> $stable(pd0_q));

  // R12
  bad_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && reg_we_i && reg_addr_i == 2'd3 &&
     (reg_wdata_i[2:0] == 3'd0 || reg_wdata_i[2:0] == 3'd7)) |=> !busy_o);
endmodule

bind sw_tlb sw_tlb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .busy_o      (busy_o),
  .utlb_inv_o  (utlb_inv_o),
  .pd0_q       (pd0_q)
);

// File: tb/sw_tlb_test.sv
`timescale 1ns/1ps
module sw_tlb_test;
  localparam int unsigned SETS = 8;
  localparam int unsigned WAYS = 4;
  localparam int unsigned PB   = 13;
  localparam int unsigned NENT = SETS * WAYS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, utlb;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sw_tlb #(.SETS(SETS), .WAYS(WAYS), .PAGE_BITS(PB)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .busy_o      (busy),
    .utlb_inv_o  (utlb)
  );

  function automatic logic [31:0] pd0_of(int i);
    int s = i / WAYS;
    int w = i % WAYS;
    return (32'((w + 1) * SETS + s) << PB) | (32'h1 << 8) | 32'(i + 16);
  endfunction

  function automatic logic [31:0] pd1_of(int i);
    return 32'hA000_0000 | (32'(i) << PB) | 32'(i % 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_cmd(input logic [2:0] c, output int bcyc, output logic inv);
    wr_reg(2'd3, {29'd0, c});
    bcyc = 0;
    while (busy && bcyc < 10) begin
      bcyc++;
      @(negedge clk);
    end
    inv = utlb;
  endtask

  task automatic wr_ent(input int idx, input logic [31:0] p0, input logic [31:0] p1,
                        input logic normal, input string req);
    int bc;
    logic iv;
    wr_reg(2'd0, p0);
    wr_reg(2'd1, p1);
    wr_reg(2'd2, 32'(idx));
    do_cmd(normal ? 3'd2 : 3'd3, bc, iv);
    check("R2 busy length", 32'(bc), 32'd2);
    check(req, {31'd0, iv}, {31'd0, normal});
  endtask

  task automatic probe(input logic [31:0] key, input logic [31:0] exp, input string req);
    int bc;
    logic iv;
    logic [31:0] d;
    wr_reg(2'd0, key);
    do_cmd(3'd4, bc, iv);
    rd_reg(2'd2, d);
    check(req, d, exp);
  endtask

  task automatic get_idx(input int set, input int exp, input string req);
    int bc;
    logic iv;
    logic [31:0] d;
    wr_reg(2'd0, 32'(set) << PB);
    do_cmd(3'd5, bc, iv);
    rd_reg(2'd2, d);
    check(req, d, 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int bc;
    logic iv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(2'd0, d); check("R1 pd0 reset", d, '0);
    rd_reg(2'd1, d); check("R1 pd1 reset", d, '0);
    rd_reg(2'd2, d); check("R1 index reset", d, '0);
    check("R1 busy/inv reset", {30'd0, busy, utlb}, '0);

    // clear whole array with no-invalidate writes
    for (int i = 0; i < NENT; i++) wr_ent(i, '0, '0, 1'b0, "R10 write-ni no pulse");

    // R7 erased slots never hit
    probe(32'h0, 32'h8000_0000, "R7 zero key on erased");
    probe(32'h100, 32'h8000_0000, "R7 valid-only key on erased");

    // R3 fill with normal writes (pulse expected, R10)
    for (int i = 0; i < NENT; i++) wr_ent(i, pd0_of(i), pd1_of(i), 1'b1, "R10 write pulse");

    for (int i = 0; i < NENT; i++) begin
      wr_reg(2'd0, '0);
      wr_reg(2'd1, '0);
      wr_reg(2'd2, 32'(i));
      do_cmd(3'd1, bc, iv);
      rd_reg(2'd0, d); check("R3 read pd0", d, pd0_of(i));
      rd_reg(2'd1, d); check("R3 read pd1", d, pd1_of(i));
    end

    // R4 every slot found at set*WAYS+way
    for (int i = 0; i < NENT; i++) probe(pd0_of(i), 32'(i), "R4 probe hit");

    // R5 misses
    probe(pd0_of(3) ^ 32'h1, 32'h8000_0000, "R5 wrong tag");
    probe(pd0_of(3) ^ (32'h1 << 20), 32'h8000_0000, "R5 wrong page");

    // R6 duplicate: slot 5 copies slot 4
    wr_ent(5, pd0_of(4), pd1_of(4), 1'b0, "R10 write-ni no pulse");
    probe(pd0_of(4), 32'h8000_0001, "R6 duplicate");
    wr_ent(5, '0, '0, 1'b1, "R10 write pulse");
    probe(pd0_of(4), 32'd4, "R7 erased duplicate gone");
    wr_ent(5, pd0_of(5), pd1_of(5), 1'b0, "R10 write-ni no pulse");

    // R8 lowest empty way
    wr_ent(10, '0, '0, 1'b0, "R10 write-ni no pulse");
    get_idx(2, 10, "R8 single hole");
    wr_ent(9, '0, '0, 1'b0, "R10 write-ni no pulse");
    get_idx(2, 9, "R8 lowest of two holes");
    wr_ent(9, pd0_of(9), pd1_of(9), 1'b0, "R10 write-ni no pulse");
    wr_ent(10, pd0_of(10), pd1_of(10), 1'b0, "R10 write-ni no pulse");

    // R9 round robin per set
    get_idx(3, 12, "R9 rr way0");
    get_idx(3, 13, "R9 rr way1");
    get_idx(3, 14, "R9 rr way2");
    get_idx(3, 15, "R9 rr way3");
    get_idx(3, 12, "R9 rr wrap");
    get_idx(4, 16, "R9 other set independent");
    get_idx(2, 8, "R9 set after holes starts at way0");

    // R11 invalidate command
    do_cmd(3'd6, bc, iv);
    check("R11 inv pulse", {31'd0, iv}, 32'd1);
    check("R11 busy length", 32'(bc), 32'd2);
    wr_reg(2'd2, 32'd7);
    do_cmd(3'd1, bc, iv);
    rd_reg(2'd0, d); check("R11 array kept pd0", d, pd0_of(7));
    rd_reg(2'd1, d); check("R11 array kept pd1", d, pd1_of(7));

    // R12 write while busy ignored
    wr_reg(2'd0, pd0_of(7));
    wr_reg(2'd3, 32'd4);
    we = 1'b1; addr = 2'd0; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    we = 1'b0;
    while (busy) @(negedge clk);
    rd_reg(2'd0, d); check("R12 pd0 kept while busy", d, pd0_of(7));
    rd_reg(2'd2, d); check("R4 probe after busy write", d, 32'd7);

    // R12 unknown codes
    wr_reg(2'd3, 32'd7);
    check("R12 code 7 idle", {31'd0, busy}, 32'd0);
    wr_reg(2'd3, 32'd0);
    check("R12 code 0 idle", {31'd0, busy}, 32'd0);
    rd_reg(2'd2, d); check("R12 index unchanged", d, 32'd7);
    rd_reg(2'd0, d); check("R12 pd0 unchanged", d, pd0_of(7));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule